// File: doc/BRIEF.md
# Dual-Issue Warp Dispatch Arbiter

This block decides, every cycle, which of two scheduler offers may issue into the execution resources of one multiprocessor. The resources form four groups of unequal width: two 16-lane arithmetic columns, a 16-lane memory-access group and a 4-lane transcendental group. Each offer covers a whole warp of threads and carries an operation class and a warp number. A granted instruction keeps its group busy for as many cycles as the warp needs to pass through the group's lanes.

Grants are decided combinationally in the cycle of the offer. A per-group down-counter tracks occupancy, and a group is free once its counter reads zero. A wide (double-precision) arithmetic operation claims both columns together. When both schedulers want the last free resource, the scheduler that currently holds priority wins, and priority passes to the other scheduler after every such clash. A scheduler that is not granted sees a stall and offers the same instruction again.

Top module: `warp_issue_arb`

## Requirements
- R1: Operation class codes are 0 narrow arithmetic, 1 wide arithmetic, 2 memory access and 3 transcendental. Group indices are 0 column A, 1 column B, 2 memory access and 3 transcendental. A wide grant reports index 0.
- R2: A grant comes in the same cycle as a valid offer and never without one. Stall is high exactly when an offer is valid and not granted.
- R3: A 16-lane group granted in cycle t refuses any new grant in cycle t+1 and accepts one again in cycle t+2.
- R4: The transcendental group granted in cycle t refuses grants in cycles t+1 to t+7 and accepts one in cycle t+8.
- R5: A busy transcendental group stalls only transcendental offers. Offers to the other groups are still granted in those cycles.
- R6: A wide arithmetic offer is granted only when both columns are free, and it then holds both columns for 2 cycles.
- R7: A narrow arithmetic offer goes to column A when A is free, and to column B when only B is free.
- R8: Two offers are both granted in one cycle when their resource needs do not overlap, and no two grants in one cycle share a group.
- R9: A clash means both offers are valid, each could be granted alone, and only one can be granted. After reset scheduler 0 wins clashes, and the winner alternates after each clash. Cycles with no clash leave priority unchanged.
- R10: A synchronous active-high reset frees every group and returns clash priority to scheduler 0.
- R11: Each grant carries the warp number of the granted offer on that scheduler's warp output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Scheduler 0 offers an instruction |
| s0_op | input | 2 | Scheduler 0 operation class |
| s0_wid | input | WID_W | Scheduler 0 warp number |
| s1_vld | input | 1 | Scheduler 1 offers an instruction |
| s1_op | input | 2 | Scheduler 1 operation class |
| s1_wid | input | WID_W | Scheduler 1 warp number |
| s0_gnt | output | 1 | Scheduler 0 granted this cycle |
| s0_gnt_grp | output | 2 | Group granted to scheduler 0 |
| s0_gnt_wid | output | WID_W | Warp number granted to scheduler 0 |
| s0_stall | output | 1 | Scheduler 0 offer refused |
| s1_gnt | output | 1 | Scheduler 1 granted this cycle |
| s1_gnt_grp | output | 2 | Group granted to scheduler 1 |
| s1_gnt_wid | output | WID_W | Warp number granted to scheduler 1 |
| s1_stall | output | 1 | Scheduler 1 offer refused |

## Verification
The bench builds the block with its defaults: a 32-thread warp, 16 lanes in each column and in the memory group, and 4 transcendental lanes. This gives occupancies of 2 and 8 cycles, so the bench can offer a second instruction exactly one cycle early and exactly on the cycle a group frees, including the eighth-cycle edge of the narrow group. With the default 5-bit warp field, distinct warp numbers show which offer each grant belongs to. A run of clashes under several class pairings, followed by a reset in mid-run, exposes the priority toggling and its return to scheduler 0.

// File: rtl/wia_pkg.sv
`timescale 1ns/1ps
package wia_pkg;
   typedef enum logic [1:0] {
      OP_SP   = 2'd0,
      OP_DP   = 2'd1,
      OP_LDST = 2'd2,
      OP_SFU  = 2'd3
   } op_e;

   localparam int NGRP = 4;
   localparam logic [1:0] GRP_COLA = 2'd0;
   localparam logic [1:0] GRP_COLB = 2'd1;
   localparam logic [1:0] GRP_LDST = 2'd2;
   localparam logic [1:0] GRP_SFU  = 2'd3;
endpackage

// File: rtl/wia_busy_ctr.sv
`timescale 1ns/1ps
// Occupancy counter for one resource group: loaded on grant, free at zero.
module wia_busy_ctr #(
   parameter int OCC = 2,
   parameter int CW  = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic free
);
   if (OCC < 1) begin : g_bad_occ
      $error("wia_busy_ctr: OCC must be at least 1");
   end
   if ((1 << CW) <= OCC) begin : g_bad_cw
      $error("wia_busy_ctr: CW too narrow for OCC");
   end

   localparam logic [CW-1:0] RELOAD = CW'(OCC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= RELOAD;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign free = (cnt == '0);
endmodule

// File: rtl/wia_route.sv
`timescale 1ns/1ps
// Maps one operation class onto the groups that are still available.
module wia_route
   import wia_pkg::*;
(
   input  logic [1:0]      op,
   input  logic [NGRP-1:0] avail,
   output logic            ok,
   output logic [NGRP-1:0] take,
   output logic [1:0]      grp
);
   always_comb begin
      take = '0;
      grp  = GRP_COLA;
      case (op_e'(op))
         OP_SP: begin
            if (avail[GRP_COLA]) begin
               take[GRP_COLA] = 1'b1;
               grp            = GRP_COLA;
            end else if (avail[GRP_COLB]) begin
               take[GRP_COLB] = 1'b1;
               grp            = GRP_COLB;
            end
         end
         OP_DP: begin
            if (avail[GRP_COLA] && avail[GRP_COLB]) begin
               take[GRP_COLA] = 1'b1;
               take[GRP_COLB] = 1'b1;
               grp            = GRP_COLA;
            end
         end
         OP_LDST: begin
            if (avail[GRP_LDST]) begin
               take[GRP_LDST] = 1'b1;
               grp            = GRP_LDST;
            end
         end
         default: begin
            if (avail[GRP_SFU]) begin
               take[GRP_SFU] = 1'b1;
               grp           = GRP_SFU;
            end
         end
      endcase
      ok = |take;
   end
endmodule

// File: rtl/wia_prio.sv
`timescale 1ns/1ps
// Clash priority holder: 0 favours scheduler 0, flips on each clash.
module wia_prio (
   input  logic clk,
   input  logic rst,
   input  logic flip,
   output logic pri
);
   always_ff @(posedge clk) begin
      if (rst)
         pri <= 1'b0;
      else if (flip)
         pri <= ~pri;
   end
endmodule

// File: rtl/warp_issue_arb.sv
`timescale 1ns/1ps
module warp_issue_arb
   import wia_pkg::*;
#(
   parameter int WARP_SIZE  = 32,
   parameter int CORE_LANES = 16,
   parameter int LDST_LANES = 16,
   parameter int SFU_LANES  = 4,
   parameter int WID_W      = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             s0_vld,
   input  logic [1:0]       s0_op,
   input  logic [WID_W-1:0] s0_wid,
   input  logic             s1_vld,
   input  logic [1:0]       s1_op,
   input  logic [WID_W-1:0] s1_wid,
   output logic             s0_gnt,
   output logic [1:0]       s0_gnt_grp,
   output logic [WID_W-1:0] s0_gnt_wid,
   output logic             s0_stall,
   output logic             s1_gnt,
   output logic [1:0]       s1_gnt_grp,
   output logic [WID_W-1:0] s1_gnt_wid,
   output logic             s1_stall
);
   localparam int CORE_OCC = WARP_SIZE / CORE_LANES;
   localparam int LDST_OCC = WARP_SIZE / LDST_LANES;
   localparam int SFU_OCC  = WARP_SIZE / SFU_LANES;
   localparam int MAX_A    = (CORE_OCC > LDST_OCC) ? CORE_OCC : LDST_OCC;
   localparam int MAX_OCC  = (MAX_A > SFU_OCC) ? MAX_A : SFU_OCC;
   localparam int CW       = $clog2(MAX_OCC + 1);

   if (CORE_LANES < 1 || LDST_LANES < 1 || SFU_LANES < 1) begin : g_bad_lanes
      $error("warp_issue_arb: lane counts must be positive");
   end
   if ((WARP_SIZE % CORE_LANES) != 0 || (WARP_SIZE % LDST_LANES) != 0 ||
       (WARP_SIZE % SFU_LANES) != 0) begin : g_bad_div
      $error("warp_issue_arb: lane counts must divide the warp size");
   end
   if (WID_W < 1) begin : g_bad_wid
      $error("warp_issue_arb: WID_W must be at least 1");
   end

   // ---------------- group occupancy ----------------
   logic [NGRP-1:0] free;
   logic [NGRP-1:0] load;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int OCC = (g == int'(GRP_SFU))  ? SFU_OCC  :
                           (g == int'(GRP_LDST)) ? LDST_OCC : CORE_OCC;
      wia_busy_ctr #(.OCC(OCC), .CW(CW)) u_ctr (
         .clk  (clk),
         .rst  (rst),
         .load (load[g]),
         .free (free[g])
      );
   end

   // ---------------- routing: alone and after the other ----------------
   logic            okf0, okf1, okr0, okr1;
   logic [NGRP-1:0] tkf0, tkf1, tkr0, tkr1;
   logic [1:0]      gpf0, gpf1, gpr0, gpr1;
   logic [NGRP-1:0] held0, held1;

   wia_route u_rf0 (.op(s0_op), .avail(free), .ok(okf0), .take(tkf0), .grp(gpf0));
   wia_route u_rf1 (.op(s1_op), .avail(free), .ok(okf1), .take(tkf1), .grp(gpf1));

   assign held0 = (s0_vld && okf0) ? tkf0 : '0;
   assign held1 = (s1_vld && okf1) ? tkf1 : '0;

   wia_route u_rr0 (.op(s0_op), .avail(free & ~held1), .ok(okr0), .take(tkr0), .grp(gpr0));
   wia_route u_rr1 (.op(s1_op), .avail(free & ~held0), .ok(okr1), .take(tkr1), .grp(gpr1));

   // ---------------- priority and final choice ----------------
   logic            pri;
   logic            clash;
   logic            g0, g1;
   logic [NGRP-1:0] m0, m1;
   logic [1:0]      p0, p1;

   always_comb begin
      if (!pri) begin
         g0    = s0_vld && okf0;
         m0    = tkf0;
         p0    = gpf0;
         g1    = s1_vld && okr1;
         m1    = tkr1;
         p1    = gpr1;
         clash = g0 && s1_vld && okf1 && !okr1;
      end else begin
         g1    = s1_vld && okf1;
         m1    = tkf1;
         p1    = gpf1;
         g0    = s0_vld && okr0;
         m0    = tkr0;
         p0    = gpr0;
         clash = g1 && s0_vld && okf0 && !okr0;
      end
   end

   wia_prio u_prio (.clk(clk), .rst(rst), .flip(clash), .pri(pri));

   assign load = (g0 ? m0 : '0) | (g1 ? m1 : '0);

   // ---------------- outputs ----------------
   assign s0_gnt     = g0;
   assign s0_gnt_grp = g0 ? p0 : 2'd0;
   assign s0_gnt_wid = g0 ? s0_wid : '0;
   assign s0_stall   = s0_vld && !g0;
   assign s1_gnt     = g1;
   assign s1_gnt_grp = g1 ? p1 : 2'd0;
   assign s1_gnt_wid = g1 ? s1_wid : '0;
   assign s1_stall   = s1_vld && !g1;
endmodule

// File: rtl/wia_chk.sv
`timescale 1ns/1ps
module wia_chk
   import wia_pkg::*;
#(
   parameter int SFU_OCC = 8
) (
   input logic       clk,
   input logic       rst,
   input logic       s0_vld,
   input logic [1:0] s0_op,
   input logic       s0_gnt,
   input logic [1:0] s0_gnt_grp,
   input logic       s0_stall,
   input logic       s1_vld,
   input logic [1:0] s1_op,
   input logic       s1_gnt,
   input logic [1:0] s1_gnt_grp,
   input logic       s1_stall
);
   function automatic logic [3:0] use_mask(logic g, logic [1:0] op, logic [1:0] grp);
      if (!g) return 4'b0000;
      if (op == 2'd1) return 4'b0011;
      return 4'b0001 << grp;
   endfunction

   logic [3:0] u0, u1, uall;
   assign u0   = use_mask(s0_gnt, s0_op, s0_gnt_grp);
   assign u1   = use_mask(s1_gnt, s1_op, s1_gnt_grp);
   assign uall = u0 | u1;

   localparam int AW = $clog2(SFU_OCC + 1);
   logic [AW-1:0] sfu_age;
   always_ff @(posedge clk) begin
      if (rst)
         sfu_age <= '0;
      else if (uall[3])
         sfu_age <= AW'(1);
      else if (sfu_age != '0 && sfu_age < AW'(SFU_OCC))
         sfu_age <= sfu_age + 1'b1;
   end

   a_r2_gnt0_vld: assert property (@(posedge clk) disable iff (rst) s0_gnt |-> s0_vld);
   a_r2_gnt1_vld: assert property (@(posedge clk) disable iff (rst) s1_gnt |-> s1_vld);
   a_r2_excl0: assert property (@(posedge clk) disable iff (rst) s0_vld |-> (s0_gnt != s0_stall));
   a_r2_excl1: assert property (@(posedge clk) disable iff (rst) s1_vld |-> (s1_gnt != s1_stall));
   a_r8_no_share: assert property (@(posedge clk) disable iff (rst) (u0 & u1) == 4'b0000);
   a_r3_ldst_hold: assert property (@(posedge clk) disable iff (rst) uall[2] |=> !uall[2]);
   a_r6_cola_hold: assert property (@(posedge clk) disable iff (rst) uall[0] |=> !uall[0]);
   a_r6_colb_hold: assert property (@(posedge clk) disable iff (rst) uall[1] |=> !uall[1]);
   a_r4_sfu_window: assert property (@(posedge clk) disable iff (rst)
      uall[3] |-> (sfu_age == '0 || sfu_age >= AW'(SFU_OCC)));
   a_r10_free_after_rst: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && s0_vld) |-> s0_gnt);
endmodule

bind warp_issue_arb wia_chk #(.SFU_OCC(SFU_OCC)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .s0_vld     (s0_vld),
   .s0_op      (s0_op),
   .s0_gnt     (s0_gnt),
   .s0_gnt_grp (s0_gnt_grp),
   .s0_stall   (s0_stall),
   .s1_vld     (s1_vld),
   .s1_op      (s1_op),
   .s1_gnt     (s1_gnt),
   .s1_gnt_grp (s1_gnt_grp),
   .s1_stall   (s1_stall)
);

// File: tb/warp_issue_arb_tb.sv
`timescale 1ns/1ps
module warp_issue_arb_tb;
   localparam logic [1:0] SP = 2'd0, DP = 2'd1, LS = 2'd2, SF = 2'd3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       s0_vld = 1'b0, s1_vld = 1'b0;
   logic [1:0] s0_op = 2'd0, s1_op = 2'd0;
   logic [4:0] s0_wid = 5'd0, s1_wid = 5'd0;
   logic       s0_gnt, s0_stall, s1_gnt, s1_stall;
   logic [1:0] s0_gnt_grp, s1_gnt_grp;
   logic [4:0] s0_gnt_wid, s1_gnt_wid;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   warp_issue_arb u_dut (
      .clk(clk), .rst(rst),
      .s0_vld(s0_vld), .s0_op(s0_op), .s0_wid(s0_wid),
      .s1_vld(s1_vld), .s1_op(s1_op), .s1_wid(s1_wid),
      .s0_gnt(s0_gnt), .s0_gnt_grp(s0_gnt_grp), .s0_gnt_wid(s0_gnt_wid), .s0_stall(s0_stall),
      .s1_gnt(s1_gnt), .s1_gnt_grp(s1_gnt_grp), .s1_gnt_wid(s1_gnt_wid), .s1_stall(s1_stall)
   );

   typedef struct {
      bit       g0; bit [1:0] p0; bit [4:0] w0; bit st0;
      bit       g1; bit [1:0] p1; bit [4:0] w1; bit st1;
      string    tag;
   } exp_t;
   exp_t q[$];

   task automatic chk(input bit ok, input string what, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
      end
   endtask

   // Driver: applies one cycle of offers and queues what the requirements predict.
   task automatic step(input bit v0, input logic [1:0] o0, input logic [4:0] w0,
                       input bit v1, input logic [1:0] o1, input logic [4:0] w1,
                       input bit e0, input logic [1:0] ep0,
                       input bit e1, input logic [1:0] ep1, input string tag);
      exp_t it;
      @(posedge clk); #1;
      s0_vld = v0; s0_op = o0; s0_wid = w0;
      s1_vld = v1; s1_op = o1; s1_wid = w1;
      it.g0 = e0; it.p0 = ep0; it.w0 = w0; it.st0 = v0 && !e0;
      it.g1 = e1; it.p1 = ep1; it.w1 = w1; it.st1 = v1 && !e1;
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle(input string tag);
      step(0, SP, 0, 0, SP, 0, 0, 0, 0, 0, tag);
   endtask

   // Monitor: compares at the falling edge, half a cycle after the offers.
   initial begin
      exp_t it;
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            it = q.pop_front();
            chk(s0_gnt == it.g0, {"R2 s0 grant ", it.tag}, s0_gnt, it.g0);
            chk(s0_stall == it.st0, {"R2 s0 stall ", it.tag}, s0_stall, it.st0);
            chk(s1_gnt == it.g1, {"R2 s1 grant ", it.tag}, s1_gnt, it.g1);
            chk(s1_stall == it.st1, {"R2 s1 stall ", it.tag}, s1_stall, it.st1);
            if (it.g0) begin
               chk(s0_gnt_grp == it.p0, {"R1 s0 group ", it.tag}, s0_gnt_grp, it.p0);
               chk(s0_gnt_wid == it.w0, {"R11 s0 warp ", it.tag}, s0_gnt_wid, it.w0);
            end
            if (it.g1) begin
               chk(s1_gnt_grp == it.p1, {"R1 s1 group ", it.tag}, s1_gnt_grp, it.p1);
               chk(s1_gnt_wid == it.w1, {"R11 s1 warp ", it.tag}, s1_gnt_wid, it.w1);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      idle("R10 idle after reset");
      step(1, LS, 3, 1, SF, 7, 1, 2, 1, 3, "R8 R10 ldst+sfu together");
      step(1, LS, 4, 1, SP, 5, 0, 0, 1, 0, "R3 R5 R7 ldst busy, sp to column A");
      step(1, LS, 4, 1, SP, 6, 1, 2, 1, 1, "R3 R7 ldst free again, sp to column B");
      step(1, SF, 8, 1, SP, 9, 0, 0, 1, 0, "R4 R5 sfu busy, sp granted");
      step(1, SF, 8, 1, DP, 10, 0, 0, 0, 0, "R6 dp waits for column A");
      step(0, SP, 0, 1, DP, 10, 0, 0, 1, 0, "R6 dp takes both columns");
      step(1, SP, 11, 1, LS, 12, 0, 0, 1, 2, "R5 R6 both columns held");
      step(1, SP, 11, 1, SF, 13, 1, 0, 0, 0, "R4 sfu still busy at seventh cycle");
      step(0, SP, 0, 1, SF, 13, 0, 0, 1, 3, "R4 sfu free at eighth cycle");
      step(1, LS, 1, 1, LS, 2, 1, 2, 0, 0, "R9 first clash to scheduler 0");
      step(1, LS, 3, 1, LS, 2, 0, 0, 0, 0, "R9 both blocked is no clash");
      step(1, LS, 3, 1, LS, 2, 0, 0, 1, 2, "R9 second clash to scheduler 1");
      step(1, SP, 20, 1, SP, 21, 1, 0, 1, 1, "R7 R8 two sp split across columns");
      step(1, LS, 3, 0, SP, 0, 1, 2, 0, 0, "R3 ldst single");
      step(1, DP, 22, 1, DP, 23, 1, 0, 0, 0, "R6 R9 dp clash to scheduler 0");
      step(1, SP, 24, 1, SP, 25, 0, 0, 0, 0, "R6 columns held by dp");
      step(1, SP, 26, 1, DP, 27, 0, 0, 1, 0, "R9 mixed clash to scheduler 1");
      idle("R9 idle");
      step(1, DP, 28, 1, SP, 29, 1, 0, 0, 0, "R9 mixed clash to scheduler 0");
      step(1, SF, 30, 0, SP, 0, 1, 3, 0, 0, "R4 sfu free again");
      // reset in mid-run: sfu busy and priority at scheduler 1
      @(posedge clk); #1;
      s0_vld = 0; s1_vld = 0; rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      step(1, SF, 17, 1, SF, 18, 1, 3, 0, 0, "R10 reset frees sfu and priority");
      idle("R10 idle");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule